// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one external machine cycle at a time for an 8-bit processor core that has a 16-bit address space. The low half of the address and the data share one set of AD lines, and the two uses are separated in time. In the first T state the block drives the low address byte and pulses ALE so that external latches can capture it. In the following states the same lines carry write data, or they are released so that the addressed device can drive read data. Three status lines announce the kind of cycle from its first clock onward. Every bus output has its own output enable, because the pads are tri-state.

The core presents a request made of a cycle kind, an address and write data, and holds `req_valid` high until `done` pulses. The block stretches read and write cycles for as long as READY is low. It yields the bus to another master on HOLD, but only at a transfer boundary. A halt cycle parks the bus in a floating state until the next request arrives.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low, every output enable (`a_hi_oe`, `ad_oe`, `rw_oe`, `io_m_oe`) is low, and `hlda`, `ale` and `done` are low. One clock after reset is released, the bus is driven in the idle state.
- R2: A request accepted from idle or halt produces T1 on the next clock. In T1, `ale` is high for exactly one clock, `ad_oe` is high, `ad_out` carries address bits 7:0 and `a_hi` carries address bits 15:8. `ale` is low in every other state.
- R3: `req_kind` codes are: 0 memory write, 1 memory read, 2 I/O write, 3 I/O read, 4 opcode fetch, 5 interrupt acknowledge, 6 halt. The status {`io_m`,`s1`,`s0`} for each code is, in the same order: 001, 010, 101, 110, 011, 111, and for halt `s1`,`s0` = 00 with `io_m` floating (`io_m_oe` low).
- R4: The status lines hold the same value from T1 until the cycle ends, including any wait states.
- R5: Read kinds (1, 3, 4, 5) hold `rd_n` low from T2 through T3 with `ad_oe` low. `rd_data` takes `ad_in` as sampled at the clock edge that ends T3, and `done` is high for exactly the one following clock. `rd_n` and `wr_n` are never low together.
- R6: Write kinds (0, 2) drive `req_wdata` on `ad_out` with `ad_oe` high from T2 through T3. `wr_n` is low in T2 and in any wait states, and it is high in T3, so the data stays valid across the rising edge of `wr_n`.
- R7: READY is sampled at the end of T2 and at the end of each wait state. Every low sample adds one wait state, so a cycle with N low samples lasts 3+N clocks before `done`.
- R8: A HOLD raised during T1, T2 or a wait state has no effect until the clock edge that ends T3. From idle, HOLD wins over a pending request. While `hlda` is high, all four output enables are low. `hlda` rises on the clock after the edge that samples HOLD at a boundary.
- R9: `hlda` falls one clock after HOLD is seen low. The output enables stay low for one further clock, and then the bus is driven again.
- R10: A halt request produces a single T1 with `ale`, followed by a `done` pulse. After that, the address, RD/WR and IO/M enables stay low and `s1`,`s0` = 00 until the next request, which starts T1 on the following clock.
- R11: HOLD during halt raises `hlda`. After HOLD is released, the block returns to the floating halt state rather than to idle.
- R12: In idle with no HOLD, the upper address, RD/WR and IO/M lines are driven, `rd_n` and `wr_n` are high, and `ad_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request pending, held until `done` |
| req_kind | input | 3 | Cycle kind code (R3) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Captured read data |
| a_hi | output | 8 | Upper address byte |
| a_hi_oe | output | 1 | Enable for `a_hi` |
| ad_out | output | 8 | Multiplexed address/data out |
| ad_oe | output | 1 | Enable for `ad_out` |
| ad_in | input | 8 | Multiplexed bus in |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rw_oe | output | 1 | Enable for `rd_n` and `wr_n` |
| io_m | output | 1 | I/O versus memory status |
| io_m_oe | output | 1 | Enable for `io_m` |
| s1 | output | 1 | Status bit 1 (early read indicator) |
| s0 | output | 1 | Status bit 0 |
| ready | input | 1 | Device ready, low inserts waits |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant acknowledge |

## Verification
The assertions assume that the core keeps `req_valid` and its request fields steady from acceptance until `done`, and that it lowers `req_valid` during the clock in which `done` is high. They also assume that `req_kind` never carries code 7. The stimulus drives every input half a clock away from the active edge and takes cycle kinds only from codes 0 to 6. It releases the request as soon as `done` is seen. HOLD is raised only in idle, in halt, or in T1 of a cycle, and READY is held low only for a bounded number of wait states.

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-DW-1:0] a_hi,
  output logic          a_hi_oe,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          rw_oe,
  output logic          io_m,
  output logic          io_m_oe,
  output logic          s1,
  output logic          s0,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda
);
  localparam logic [2:0] K_MWR = 3'd0, K_MRD = 3'd1, K_IOWR = 3'd2, K_IORD = 3'd3,
                         K_OPF = 3'd4, K_INTA = 3'd5, K_HALT = 3'd6;

  typedef enum logic [2:0] {S_REL, S_IDLE, S_T1, S_T2, S_TW, S_T3, S_HALT, S_HOLD} st_t;

  st_t st, nxt;
  logic [2:0]    kind_q, stat_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          halted_q, done_q;

  function automatic logic [2:0] stat_of(input logic [2:0] k);
    case (k)
      K_MWR:   stat_of = 3'b001;
      K_MRD:   stat_of = 3'b010;
      K_IOWR:  stat_of = 3'b101;
      K_IORD:  stat_of = 3'b110;
      K_OPF:   stat_of = 3'b011;
      K_INTA:  stat_of = 3'b111;
      K_HALT:  stat_of = 3'b000;
      default: stat_of = 3'b010;
    endcase
  endfunction

  wire is_wr   = (kind_q == K_MWR) || (kind_q == K_IOWR);
  wire is_halt = (kind_q == K_HALT);
  wire is_rd   = !is_wr && !is_halt;
  wire xfer    = (st == S_T2) || (st == S_TW) || (st == S_T3);
  wire parked  = (st == S_IDLE) || (st == S_HALT);
  wire accept  = parked && !hold && req_valid;
  wire drive   = parked ? (st == S_IDLE) : (st != S_REL && st != S_HOLD);

  always_comb begin
    nxt = st;
    case (st)
      S_REL:          nxt = halted_q ? S_HALT : S_IDLE;
      S_IDLE, S_HALT: nxt = hold ? S_HOLD : (req_valid ? S_T1 : st);
      S_T1:           nxt = is_halt ? S_HALT : S_T2;
      S_T2, S_TW:     nxt = ready ? S_T3 : S_TW;
      S_T3:           nxt = hold ? S_HOLD : S_IDLE;
      S_HOLD:         nxt = hold ? S_HOLD : S_REL;
      default:        nxt = S_REL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_REL;
      kind_q   <= K_MRD;
      stat_q   <= 3'b000;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      halted_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st     <= nxt;
      done_q <= (st == S_T3) || (st == S_T1 && is_halt);
      if (accept) begin
        kind_q   <= req_kind;
        stat_q   <= stat_of(req_kind);
        addr_q   <= req_addr;
        wdata_q  <= req_wdata;
        halted_q <= 1'b0;
      end
      if (st == S_T1 && is_halt) halted_q <= 1'b1;
      if (st == S_T3 && is_rd)   rdata_q  <= ad_in;
    end
  end

  assign done    = done_q;
  assign rd_data = rdata_q;
  assign a_hi    = addr_q[AW-1:DW];
  assign a_hi_oe = drive;
  assign rw_oe   = drive;
  assign io_m_oe = drive && !is_halt;
  assign ale     = (st == S_T1);
  assign ad_oe   = (st == S_T1) || (is_wr && xfer);
  assign ad_out  = (st == S_T1) ? addr_q[DW-1:0] : wdata_q;
  assign rd_n    = !(is_rd && xfer);
  assign wr_n    = !(is_wr && (st == S_T2 || st == S_TW));
  assign io_m    = stat_q[2];
  assign s1      = stat_q[1];
  assign s0      = stat_q[0];
  assign hlda    = (st == S_HOLD);

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  p_stat_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T2 || st == S_TW || st == S_T3) |-> $stable({io_m, s1, s0}));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_T2 || st == S_TW) && !ready) |=> (!done && (!rd_n || !wr_n)));
  p_grant_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !(a_hi_oe || ad_oe || rw_oe || io_m_oe));
  p_release_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda) |-> !(a_hi_oe || ad_oe || rw_oe));
  p_halt_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HALT) |-> (!a_hi_oe && !rw_oe && !io_m_oe && !s1 && !s0));
endmodule

// File: tb/bus_cycle_ctrl_bench.sv
module bus_cycle_ctrl_bench;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, ready = 1'b1, hold = 1'b0;
  logic [2:0] req_kind = 3'd1;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in = '0;
  logic done, ad_oe, a_hi_oe, ale, rd_n, wr_n, rw_oe, io_m, io_m_oe, s1, s0, hlda;
  logic [7:0] rd_data, a_hi, ad_out;
  int nvec = 0, nerr = 0;

  always #(TCLK/2) clk = ~clk;

  bus_cycle_ctrl u_bus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .a_hi(a_hi), .a_hi_oe(a_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .rw_oe(rw_oe), .io_m(io_m),
    .io_m_oe(io_m_oe), .s1(s1), .s0(s0), .ready(ready), .hold(hold), .hlda(hlda));

  function automatic logic [2:0] exp_stat(input logic [2:0] k);
    case (k)
      3'd0: return 3'b001;
      3'd1: return 3'b010;
      3'd2: return 3'b101;
      3'd3: return 3'b110;
      3'd4: return 3'b011;
      3'd5: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction
  function automatic bit exp_wr(input logic [2:0] k);
    return k == 3'd0 || k == 3'd2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                           input logic [7:0] rv, input int waits, input bit hmid);
    logic [2:0] es;
    bit w;
    es = exp_stat(k);
    w = exp_wr(k);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; ad_in = rv;
    @(negedge clk);
    chk("R2 ale in T1", ale, 1);
    chk("R2 ad_oe in T1", ad_oe, 1);
    chk("R2 low address", ad_out, a[7:0]);
    chk("R2 high address", a_hi, a[15:8]);
    chk("R3 s1,s0", {s1, s0}, es[1:0]);
    if (k == 3'd6) begin
      chk("R10 io_m floats", io_m_oe, 0);
      @(negedge clk);
      chk("R10 halt done", done, 1);
      chk("R10 address floats", a_hi_oe, 0);
      chk("R10 rd/wr float", rw_oe, 0);
      chk("R10 halt status", {s1, s0}, 0);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R10 stays halted", {a_hi_oe, io_m_oe, done}, 0);
      return;
    end
    chk("R3 io_m", {io_m_oe, io_m}, {1'b1, es[2]});
    if (hmid) hold = 1'b1;
    @(negedge clk);
    ready = (waits == 0);
    chk("R2 ale low in T2", ale, 0);
    chk("R5 rd_n in T2", rd_n, w);
    chk("R6 wr_n in T2", wr_n, !w);
    chk("R6 ad_oe in T2", ad_oe, w);
    chk("R4 status in T2", {io_m, s1, s0}, es);
    chk("R8 no grant mid-cycle", hlda, 0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      ready = (i + 1 >= waits);
      chk("R7 wait keeps strobe", {rd_n, wr_n, done}, {w, !w, 1'b0});
      chk("R4 status in wait", {io_m, s1, s0}, es);
    end
    @(negedge clk);
    ready = 1'b1;
    chk("R6 wr_n high in T3", wr_n, 1);
    chk("R5 rd_n in T3", rd_n, w);
    chk("R4 status in T3", {io_m, s1, s0}, es);
    chk("R7 no early done", done, 0);
    if (w) chk("R6 write data in T3", {ad_oe, ad_out}, {1'b1, wd});
    @(negedge clk);
    chk("R5 done pulse", done, 1);
    if (!w) chk("R5 read data", rd_data, rv);
    req_valid = 1'b0;
    if (hmid) begin
      chk("R8 grant after T3", hlda, 1);
      chk("R8 all float", {a_hi_oe, ad_oe, rw_oe, io_m_oe}, 0);
      hold = 1'b0;
      @(negedge clk);
      chk("R9 hlda falls", hlda, 0);
      chk("R9 still floating", {a_hi_oe, rw_oe}, 0);
      @(negedge clk);
      chk("R9 bus driven again", {a_hi_oe, rw_oe}, 2'b11);
    end else begin
      chk("R12 idle strobes", {ale, rd_n, wr_n, ad_oe}, 4'b0110);
      chk("R12 idle driven", {a_hi_oe, rw_oe, io_m_oe}, 3'b111);
      @(negedge clk);
      chk("R5 done single", done, 0);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 enables in reset", {a_hi_oe, ad_oe, rw_oe, io_m_oe}, 0);
    chk("R1 strobes in reset", {hlda, ale, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 driven after reset", {a_hi_oe, rw_oe, io_m_oe, ad_oe}, 4'b1110);

    for (int k = 0; k < 6; k++)
      run_cycle(3'(k), 16'hA55A + 16'(k * 257), 8'(8'h3C + k), 8'(8'hC3 - k), 0, 1'b0);
    run_cycle(3'd1, 16'h1234, 8'h00, 8'h9E, 3, 1'b0);
    run_cycle(3'd0, 16'hFEDC, 8'h71, 8'h00, 2, 1'b1);

    hold = 1'b1; req_valid = 1'b1; req_kind = 3'd1;
    @(negedge clk);
    chk("R8 hold beats request", {hlda, ale}, 2'b10);
    hold = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk("R9 gap after release", {hlda, a_hi_oe}, 0);
    @(negedge clk);
    chk("R9 idle resumed", a_hi_oe, 1);

    run_cycle(3'd6, 16'h0040, 8'h00, 8'h00, 0, 1'b0);
    hold = 1'b1;
    @(negedge clk);
    chk("R11 grant in halt", hlda, 1);
    hold = 1'b0;
    @(negedge clk);
    chk("R11 hlda falls", hlda, 0);
    @(negedge clk);
    chk("R11 back to halt", {a_hi_oe, s1, s0, hlda}, 0);
    run_cycle(3'd4, 16'h8001, 8'h00, 8'h5A, 1, 1'b0);

    for (int n = 0; n < 80; n++) begin
      logic [2:0] k;
      k = 3'($urandom % 6);
      if ($urandom % 8 == 0) k = 3'd6;
      run_cycle(k, 16'($urandom), 8'($urandom), 8'($urandom), int'($urandom % 4),
                (k != 3'd6) && ($urandom % 5 == 0));
    end
    summary();
  end
endmodule